// File: doc/BRIEF.md
# Perspective Rotate-Translate-Project Unit

This block is the fixed-point vertex path of a geometry engine. It rotates a signed 16-bit vertex by a 3x3 matrix, adds a translation, and reduces the result to a 32-bit and a 16-bit view of each axis. It then pushes the clamped depth into a four-entry depth history. It divides the projection distance by that depth on a bit-serial restoring divider. With the limited quotient it projects X and Y onto the screen and produces a depth-cue interpolation value.

A start pulse with `triple` low transforms vertex 0 once. With `triple` high, vertices 0, 1 and 2 are processed back to back, and each one is pushed into the depth history and the screen-coordinate history. All operands are sampled from the input ports while the operation runs, so they must stay stable until `done`. The status-flag word, lighting and colour operations belong to other blocks.

Top module: `rtp_unit`

## Requirements
- R1: For axis i (field i of `mac_o`, 32 bits each, axis 0 in the low bits; matrix entry (i,j) at `rot_m[16*(3i+j)+:16]`; vertex v component j at `verts[16*(3v+j)+:16]`; `trans_v` field i of 32 bits), the result is (translation_i * 4096 + sum over j of M(i,j)*V(j)), computed exactly, shifted arithmetically right by 12, and saturated to signed 32 bits.
- R2: Each 16-bit field of `ir_o` equals the matching `mac_o` field saturated to -32768..32767.
- R3: The new depth is MAC3 clamped to 0..65535. Each vertex shifts the depth history (`sz_o`, 16-bit slots, slot 0 in the low bits), so slot k takes slot k+1 and slot 3 takes the new depth.
- R4: The divisor is the new depth only when floor(H/2) is strictly less than that depth. Otherwise the divisor is 1.
- R5: The quotient is floor(H*65536 / divisor). Any value above 0x1FFFF is replaced by 0x1FFFF.
- R6: The screen X is OFX + IR1*quotient, saturated to signed 32 bits, shifted arithmetically right by 16, and clamped to -1024..1023. Y is formed the same way from OFY and IR2. Each vertex shifts the screen history `sxy_o` (three 32-bit entries, entry 0 low, X in bits 15:0 and Y in bits 31:16 of an entry, both sign-extended), so the newest entry lands in entry 2.
- R7: `mac0_o` is DQB + DQA*quotient, saturated to signed 32 bits, taken from the last vertex of the operation.
- R8: `ir0_o` is `mac0_o` shifted arithmetically right by 12 and clamped to 0..4096.
- R9: In three-vertex mode, vertices 0, 1 and 2 are processed in that order. Afterwards depth slot 0 holds the old slot 3, slots 1 to 3 hold the three new depths, and `mac_o`/`ir_o` reflect vertex 2.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse raised as `busy` falls. A start while busy is ignored. Outputs hold while idle.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| triple | input | 1 | 1: process three vertices, 0: vertex 0 only |
| rot_m | input | 144 | Rotation matrix, nine signed 16-bit entries |
| trans_v | input | 96 | Translation, three signed 32-bit values |
| verts | input | 144 | Three vertices of three signed 16-bit components |
| proj_h | input | 16 | Unsigned projection distance H |
| off_x | input | 32 | Signed screen offset X |
| off_y | input | 32 | Signed screen offset Y |
| dq_a | input | 16 | Signed depth-cue slope |
| dq_b | input | 32 | Signed depth-cue base |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mac_o | output | 96 | MAC1..MAC3, signed 32 bits each |
| ir_o | output | 48 | IR1..IR3, signed 16 bits each |
| sz_o | output | 64 | Depth history slots 0..3 |
| sxy_o | output | 96 | Screen history entries 0..2 |
| mac0_o | output | 32 | Depth-cue accumulator |
| ir0_o | output | 16 | Depth-cue interpolation factor |

## Verification
The hardest path to reach is the divisor-of-one path, because the guard sends almost every sensible depth to the real divider. The stimulus drives MAC3 negative, pins the depth to exactly floor(H/2), and uses H values of 0 and 1, where forcing the divisor to 1 still leaves the quotient below the limit. Saturation at each stage is reached with full-scale matrix entries, extreme translations and extreme screen offsets. A second start pulse in the middle of an operation must not produce a second completion.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  localparam int CW   = 16;  // component / matrix / IR width
  localparam int TW   = 32;  // accumulator and translation width
  localparam int AW   = 64;  // wide intermediate width
  localparam int FRAC = 12;  // fractional bits of matrix products
  localparam int QW   = 17;  // limited quotient width
  localparam int SCR  = 11;  // screen coordinate width
  localparam int NV   = 3;   // vertices in three-vertex mode
  localparam int NSZ  = 4;   // depth history slots

  localparam logic [QW-1:0] QMAX = {QW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_XF, S_DIV, S_PRJ} rtp_state_e;

  function automatic logic signed [TW-1:0] sat32(input logic signed [AW-1:0] x);
    if (x > AW'(64'sd2147483647))       return 32'sh7FFFFFFF;
    else if (x < -AW'(64'sd2147483648)) return 32'sh80000000;
    else                                return x[TW-1:0];
  endfunction

  function automatic logic signed [CW-1:0] sat16(input logic signed [TW-1:0] x);
    if (x > 32'sd32767)       return 16'sh7FFF;
    else if (x < -32'sd32768) return 16'sh8000;
    else                      return x[CW-1:0];
  endfunction
endpackage

// File: rtl/rtp_xform.sv
module rtp_xform
  import rtp_pkg::*;
(
  input  logic [9*CW-1:0] rot_m,
  input  logic [3*TW-1:0] trans_v,
  input  logic [3*CW-1:0] vec,
  output logic [3*TW-1:0] mac,
  output logic [3*CW-1:0] ir
);
  for (genvar i = 0; i < 3; i++) begin : g_row
    logic signed [AW-1:0] acc;
    logic signed [TW-1:0] m;
    always_comb begin
      acc = AW'($signed(trans_v[i*TW +: TW])) <<< FRAC;
      for (int j = 0; j < 3; j++) begin
        acc = acc + AW'($signed(rot_m[(3*i+j)*CW +: CW])) * AW'($signed(vec[j*CW +: CW]));
      end
      m = sat32(acc >>> FRAC);
    end
    assign mac[i*TW +: TW] = m;
    assign ir[i*CW +: CW]  = sat16(m);
  end
endmodule

// File: rtl/rtp_div.sv
module rtp_div #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW-1:0]   rem_q, den_q;
  logic [NW-1:0]   quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic [DW:0]     trial;
  logic            fit;

  assign trial = {rem_q, quo_q[NW-1]};
  assign fit   = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run_q) begin
        if (start) begin
          rem_q <= '0;
          quo_q <= num;
          den_q <= den;
          cnt_q <= CNTW'(NW);
          run_q <= 1'b1;
        end
      end else begin
        rem_q <= fit ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
        quo_q <= {quo_q[NW-2:0], fit};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
endmodule

// File: rtl/rtp_proj.sv
module rtp_proj
  import rtp_pkg::*;
(
  input  logic signed [CW-1:0] ir1,
  input  logic signed [CW-1:0] ir2,
  input  logic        [QW-1:0] quo,
  input  logic signed [TW-1:0] off_x,
  input  logic signed [TW-1:0] off_y,
  input  logic signed [CW-1:0] dq_a,
  input  logic signed [TW-1:0] dq_b,
  output logic        [CW-1:0] sx,
  output logic        [CW-1:0] sy,
  output logic        [TW-1:0] mac0,
  output logic        [CW-1:0] ir0
);
  localparam logic signed [TW-1:0] SMAX = TW'((1 <<< (SCR-1)) - 1);
  localparam logic signed [TW-1:0] SMIN = -TW'(1 <<< (SCR-1));
  localparam logic signed [TW-1:0] IMAX = TW'(1 <<< FRAC);

  function automatic logic [CW-1:0] scr_clamp(input logic signed [TW-1:0] v);
    logic signed [TW-1:0] s;
    s = v >>> 16;
    if (s > SMAX)      return SMAX[CW-1:0];
    else if (s < SMIN) return SMIN[CW-1:0];
    else               return s[CW-1:0];
  endfunction

  logic signed [QW:0]   qs;
  logic signed [TW-1:0] m0, m0s;

  assign qs = {1'b0, quo};

  always_comb begin
    sx  = scr_clamp(sat32(AW'(off_x) + AW'(ir1) * AW'(qs)));
    sy  = scr_clamp(sat32(AW'(off_y) + AW'(ir2) * AW'(qs)));
    m0  = sat32(AW'(dq_b) + AW'(dq_a) * AW'(qs));
    m0s = m0 >>> FRAC;
    if (m0s < 0)         ir0 = '0;
    else if (m0s > IMAX) ir0 = IMAX[CW-1:0];
    else                 ir0 = m0s[CW-1:0];
    mac0 = m0;
  end
endmodule

// File: rtl/rtp_unit.sv
module rtp_unit
  import rtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              triple,
  input  logic [9*CW-1:0]   rot_m,
  input  logic [3*TW-1:0]   trans_v,
  input  logic [3*NV*CW-1:0] verts,
  input  logic [CW-1:0]     proj_h,
  input  logic [TW-1:0]     off_x,
  input  logic [TW-1:0]     off_y,
  input  logic [CW-1:0]     dq_a,
  input  logic [TW-1:0]     dq_b,
  output logic              busy,
  output logic              done,
  output logic [3*TW-1:0]   mac_o,
  output logic [3*CW-1:0]   ir_o,
  output logic [NSZ*CW-1:0] sz_o,
  output logic [NV*2*CW-1:0] sxy_o,
  output logic [TW-1:0]     mac0_o,
  output logic [CW-1:0]     ir0_o
);
  localparam int VIW = $clog2(NV);

  rtp_state_e     state;
  logic [VIW-1:0] vsel;
  logic           trip_q;
  logic [QW-1:0]  q_q;
  logic           last;

  logic [3*CW-1:0] vec_sel;
  logic [3*TW-1:0] mac_c;
  logic [3*CW-1:0] ir_c;
  logic [TW-1:0]   mac3;
  logic [CW-1:0]   sz_new, dvs;
  logic            div_done;
  logic [TW-1:0]   q_raw;
  logic [CW-1:0]   sx_c, sy_c, ir0_c;
  logic [TW-1:0]   mac0_c;

  assign vec_sel = verts[vsel*3*CW +: 3*CW];
  assign last    = !trip_q || (vsel == VIW'(NV-1));

  rtp_xform u_xf (
    .rot_m  (rot_m),
    .trans_v(trans_v),
    .vec    (vec_sel),
    .mac    (mac_c),
    .ir     (ir_c)
  );

  // depth clamp and division guard
  assign mac3   = mac_c[2*TW +: TW];
  assign sz_new = mac3[TW-1] ? '0 : ((|mac3[TW-1:CW]) ? {CW{1'b1}} : mac3[CW-1:0]);
  assign dvs    = ({1'b0, proj_h[CW-1:1]} < sz_new) ? sz_new : CW'(1);

  rtp_div #(.NW(TW), .DW(CW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(state == S_XF),
    .num  ({proj_h, {(TW-CW){1'b0}}}),
    .den  (dvs),
    .done (div_done),
    .quo  (q_raw)
  );

  rtp_proj u_pj (
    .ir1  (ir_o[0 +: CW]),
    .ir2  (ir_o[CW +: CW]),
    .quo  (q_q),
    .off_x(off_x),
    .off_y(off_y),
    .dq_a (dq_a),
    .dq_b (dq_b),
    .sx   (sx_c),
    .sy   (sy_c),
    .mac0 (mac0_c),
    .ir0  (ir0_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      vsel   <= '0;
      trip_q <= 1'b0;
      q_q    <= '0;
      done   <= 1'b0;
      mac_o  <= '0;
      ir_o   <= '0;
      sz_o   <= '0;
      sxy_o  <= '0;
      mac0_o <= '0;
      ir0_o  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          trip_q <= triple;
          vsel   <= '0;
          state  <= S_XF;
        end
        S_XF: begin
          mac_o <= mac_c;
          ir_o  <= ir_c;
          sz_o  <= {sz_new, sz_o[NSZ*CW-1:CW]};
          state <= S_DIV;
        end
        S_DIV: if (div_done) begin
          q_q   <= (|q_raw[TW-1:QW]) ? QMAX : q_raw[QW-1:0];
          state <= S_PRJ;
        end
        S_PRJ: begin
          sxy_o <= {sy_c, sx_c, sxy_o[NV*2*CW-1:2*CW]};
          if (last) begin
            mac0_o <= mac0_c;
            ir0_o  <= ir0_c;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else begin
            vsel  <= vsel + 1'b1;
            state <= S_XF;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/rtp_unit_chk.sv
module rtp_unit_chk
  import rtp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [3*TW-1:0]   mac_o,
  input logic [3*CW-1:0]   ir_o,
  input logic [NV*2*CW-1:0] sxy_o,
  input logic [CW-1:0]     ir0_o
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r10:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_fall_done_r10:  assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  p_idle_hold_r1:   assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(mac_o));
  p_ir0_range_r8:   assert property (@(posedge clk) disable iff (rst) ir0_o <= 16'h1000);

  for (genvar i = 0; i < 3; i++) begin : g_ir
    p_ir_sat_r2: assert property (@(posedge clk) disable iff (rst)
      $signed(ir_o[i*CW +: CW]) == sat16($signed(mac_o[i*TW +: TW])));
  end

  for (genvar k = 0; k < NV; k++) begin : g_scr
    p_scr_range_r6: assert property (@(posedge clk) disable iff (rst)
      ($signed(sxy_o[k*2*CW +: CW]) >= -16'sd1024) && ($signed(sxy_o[k*2*CW +: CW]) <= 16'sd1023) &&
      ($signed(sxy_o[k*2*CW+CW +: CW]) >= -16'sd1024) && ($signed(sxy_o[k*2*CW+CW +: CW]) <= 16'sd1023));
  end
endmodule

bind rtp_unit rtp_unit_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (busy),
  .done (done),
  .mac_o(mac_o),
  .ir_o (ir_o),
  .sxy_o(sxy_o),
  .ir0_o(ir0_o)
);

// File: tb/rtp_unit_tb.sv
module rtp_unit_tb;
  localparam longint MN = -64'sd2147483648;
  localparam longint MX = 64'sd2147483647;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic triple = 1'b0;
  always #4 clk = ~clk;

  logic signed [15:0] rm [3][3];
  logic signed [31:0] tr [3];
  logic signed [15:0] vx [3][3];
  logic        [15:0] h;
  logic signed [31:0] ox, oy, dqb;
  logic signed [15:0] dqa;

  logic [143:0] rot_m, verts;
  logic [95:0]  trans_v;
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      trans_v[i*32 +: 32] = tr[i];
      for (int j = 0; j < 3; j++) begin
        rot_m[(3*i+j)*16 +: 16] = rm[i][j];
        verts[(3*i+j)*16 +: 16] = vx[i][j];
      end
    end
  end

  logic busy, done;
  logic [95:0] mac_o, sxy_o;
  logic [47:0] ir_o;
  logic [63:0] sz_o;
  logic [31:0] mac0_o;
  logic [15:0] ir0_o;

  rtp_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .triple(triple),
    .rot_m(rot_m), .trans_v(trans_v), .verts(verts), .proj_h(h),
    .off_x(ox), .off_y(oy), .dq_a(dqa), .dq_b(dqb),
    .busy(busy), .done(done), .mac_o(mac_o), .ir_o(ir_o), .sz_o(sz_o),
    .sxy_o(sxy_o), .mac0_o(mac0_o), .ir0_o(ir0_o)
  );

  int n_chk = 0, n_fail = 0, n_done = 0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  longint em[3], ei[3], e_m0, e_i0, msz[4], msx[3], msy[3];

  function automatic longint clampl(longint x, longint lo, longint hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  task automatic model_vertex(int v, bit last);
    longint acc, szn, dvs, qv, t;
    for (int i = 0; i < 3; i++) begin
      acc = longint'(tr[i]) <<< 12;
      for (int j = 0; j < 3; j++) acc += longint'(rm[i][j]) * longint'(vx[v][j]);
      em[i] = clampl(acc >>> 12, MN, MX);
      ei[i] = clampl(em[i], -32768, 32767);
    end
    szn = clampl(em[2], 0, 65535);                    // R3
    for (int k = 0; k < 3; k++) msz[k] = msz[k+1];
    msz[3] = szn;
    dvs = ((longint'(h) >> 1) < szn) ? szn : 1;       // R4
    qv  = (longint'(h) << 16) / dvs;
    if (qv > 131071) qv = 131071;                     // R5
    for (int k = 0; k < 2; k++) begin msx[k] = msx[k+1]; msy[k] = msy[k+1]; end
    t = clampl(longint'(ox) + ei[0] * qv, MN, MX) >>> 16;
    msx[2] = clampl(t, -1024, 1023);
    t = clampl(longint'(oy) + ei[1] * qv, MN, MX) >>> 16;
    msy[2] = clampl(t, -1024, 1023);
    if (last) begin
      e_m0 = clampl(longint'(dqb) + longint'(dqa) * qv, MN, MX);
      e_i0 = clampl(e_m0 >>> 12, 0, 4096);
    end
  endtask

  typedef struct {
    string tag;
    logic [95:0] mac;
    logic [47:0] ir;
    logic [63:0] sz;
    logic [95:0] sxy;
    logic [31:0] mac0;
    logic [15:0] ir0;
  } exp_t;
  exp_t sb[$];

  task automatic wait_done(int target);
    int n = 0;
    while (n_done < target && n < 3000) begin @(posedge clk); n++; end
    if (n_done < target) chk("R10 completion timeout", 0, 1);
  endtask

  task automatic run(string tag, bit trip);
    exp_t e;
    int nv = trip ? 3 : 1;
    for (int v = 0; v < nv; v++) model_vertex(v, v == nv - 1);
    e.tag = tag;
    for (int i = 0; i < 3; i++) begin
      e.mac[i*32 +: 32] = em[i][31:0];
      e.ir[i*16 +: 16]  = ei[i][15:0];
      e.sxy[i*32 +: 32] = {msy[i][15:0], msx[i][15:0]};
    end
    for (int k = 0; k < 4; k++) e.sz[k*16 +: 16] = msz[k][15:0];
    e.mac0 = e_m0[31:0];
    e.ir0  = e_i0[15:0];
    sb.push_back(e);
    @(negedge clk); start = 1'b1; triple = trip;
    @(negedge clk); start = 1'b0; triple = 1'b0;
    wait_done(n_done + 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (sb.size() == 0) chk("R10 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " R1 mac"},  mac_o,  e.mac);
        chk({e.tag, " R2 ir"},   ir_o,   e.ir);
        chk({e.tag, " R3 sz"},   sz_o,   e.sz);
        chk({e.tag, " R6 sxy"},  sxy_o,  e.sxy);
        chk({e.tag, " R7 mac0"}, mac0_o, e.mac0);
        chk({e.tag, " R8 ir0"},  ir0_o,  e.ir0);
      end
    end
  end

  task automatic set_ident();
    for (int i = 0; i < 3; i++) begin
      tr[i] = 0;
      for (int j = 0; j < 3; j++) begin
        rm[i][j] = (i == j) ? 16'sh1000 : 16'sh0;
        vx[i][j] = 0;
      end
    end
    ox = 0; oy = 0; dqa = 0; dqb = 0; h = 0;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int seed, base;
    for (int k = 0; k < 4; k++) msz[k] = 0;
    for (int k = 0; k < 3; k++) begin msx[k] = 0; msy[k] = 0; end
    set_ident();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy/done", {busy, done}, 0);
    chk("R11 mac/ir", {mac_o, ir_o}, 0);
    chk("R11 sz/sxy", {sz_o, sxy_o}, 0);
    chk("R11 mac0/ir0", {mac0_o, ir0_o}, 0);

    // R1 basic identity transform and divide
    vx[0][0] = 100; vx[0][1] = 200; vx[0][2] = 300;
    h = 200; dqa = 100; dqb = 32'sh100000; ox = 32'sh01000000; oy = -32'sh00800000;
    run("R1 basic", 0);

    // R2 saturation, depth clamp high, IR0 clamp high
    for (int i = 0; i < 3; i++) rm[i][i] = 16'sh7FFF;
    vx[0][0] = 32767; vx[0][1] = -32768; vx[0][2] = 20000;
    tr[2] = 32'sh7FFF0000; h = 16'hFFFF; dqa = 16'sh7FFF; dqb = 32'sh7FFF0000;
    run("R2 saturate", 0);

    // R4/R5 negative depth: divisor forced to 1, quotient limited, screen clamps
    set_ident();
    tr[2] = -5000; vx[0][0] = 300; vx[0][1] = -300; h = 1000;
    ox = 32'sh10000000; oy = -32'sh10000000; dqa = -16'sh7FFF; dqb = 0;
    run("R4 negdepth", 0);
    // R5 H=1 and H=0 with zero depth: quotient not limited
    h = 1; run("R5 h1", 0);
    h = 0; run("R5 h0", 0);

    // R4 guard boundary: depth equal to H/2 and one above
    set_ident();
    vx[0][0] = 50; vx[0][1] = -70; vx[0][2] = 300; h = 600; dqa = 3; dqb = 100;
    run("R4 eq", 0);
    vx[0][2] = 301; run("R4 above", 0);

    // R9 three-vertex mode
    for (int v = 0; v < 3; v++) begin
      vx[v][0] = 16'(40 * (v + 1)); vx[v][1] = 16'(-25 * (v + 2)); vx[v][2] = 16'(500 + 700 * v);
    end
    h = 400; ox = 32'sh00400000; oy = 32'sh00200000; dqa = -400; dqb = 32'sh01000000;
    run("R9 triple", 1);

    // R1 mixed patterns
    seed = 12345;
    for (int n = 0; n < 12; n++) begin
      for (int i = 0; i < 3; i++) begin
        seed = seed * 1103515245 + 12345; tr[i] = (seed >>> 8) % 4000;
        for (int j = 0; j < 3; j++) begin
          seed = seed * 1103515245 + 12345; rm[i][j] = 16'(seed >>> 12);
          seed = seed * 1103515245 + 12345; vx[i][j] = 16'((seed >>> 10) % 3000);
        end
      end
      seed = seed * 1103515245 + 12345; h = 16'(seed >>> 9);
      seed = seed * 1103515245 + 12345; ox = seed >>> 5;
      seed = seed * 1103515245 + 12345; oy = seed >>> 5;
      seed = seed * 1103515245 + 12345; dqa = 16'(seed >>> 7);
      seed = seed * 1103515245 + 12345; dqb = seed >>> 3;
      run(n[0] ? "R9 mixed" : "R1 mixed", n[0]);
    end

    // R10 start while busy is ignored
    base = n_done;
    model_vertex(0, 1);
    begin
      exp_t e;
      e.tag = "R10 restart";
      for (int i = 0; i < 3; i++) begin
        e.mac[i*32 +: 32] = em[i][31:0];
        e.ir[i*16 +: 16]  = ei[i][15:0];
        e.sxy[i*32 +: 32] = {msy[i][15:0], msx[i][15:0]};
      end
      for (int k = 0; k < 4; k++) e.sz[k*16 +: 16] = msz[k][15:0];
      e.mac0 = e_m0[31:0]; e.ir0 = e_i0[15:0];
      sb.push_back(e);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 busy during run", busy, 1);
    start = 1'b1; triple = 1'b1;
    @(negedge clk); start = 1'b0; triple = 1'b0;
    wait_done(base + 1);
    repeat (200) @(negedge clk);
    chk("R10 single completion", n_done, base + 1);
    chk("R10 idle after done", busy, 0);

    finish_up();
  end
endmodule